// File: doc/BRIEF.md
# Packed 52-bit Multiply-Accumulate Unit

This block is a vector integer datapath of up to eight 64-bit lanes. In each lane it keeps only the low 52 bits of the two multiplicand lanes and forms their 104-bit product. It then adds either the lower or the upper 52-bit half of that product, zero-extended, to the full 64-bit accumulator lane. The sum wraps modulo 2^64. Arithmetic of this kind is used to build multi-precision modular multiplication out of 52-bit limbs.

A single start pulse captures all operands and control. A one-cycle done pulse follows three cycles later, and the result vector is held until the next operation completes. A vector-length code sets how many lanes are active. With masking turned on, a per-lane mask decides which lanes receive the sum. A lane whose mask bit is clear either keeps its accumulator value or is cleared, depending on a merge/zero flag. Lanes above the active length always come out as zero.

Top module: `pmac52_unit`

## Requirements
- R1: Bits 63:52 of both multiplicand lanes have no effect; only bits 51:0 enter the multiply.
- R2: With `hi_sel_i` = 0, bits 51:0 of the 104-bit product are zero-extended and added to the accumulator lane.
- R3: With `hi_sel_i` = 1, bits 103:52 of the product are zero-extended and added to the accumulator lane.
- R4: The accumulator lane is used at its full 64 bits, and the sum wraps modulo 2^64 with no carry-out.
- R5: With `mask_en_i` = 1, bit n of `mask_i` governs lane n, and a set bit writes the new sum.
- R6: With `mask_en_i` = 1 and `zero_mask_i` = 0, an active lane whose mask bit is clear outputs its accumulator value unchanged.
- R7: With `mask_en_i` = 1 and `zero_mask_i` = 1, an active lane whose mask bit is clear outputs zero.
- R8: With `mask_en_i` = 0, every active lane receives its sum, whatever `mask_i` holds.
- R9: `vlen_i` selects the active lanes: 2'b00 gives lanes 0-1, 2'b01 gives lanes 0-3, and 2'b10 or 2'b11 gives lanes 0-7. Lanes at or above the active count output zero regardless of mask.
- R10: The edge that accepts a start is followed by `done_o` high for exactly one cycle after the third rising edge, counting that edge. `dst_o` changes only when `done_o` rises.
- R11: A start raised while `busy_o` is high is ignored: it produces neither a done pulse nor a change of result.
- R12: While `rst_n` is low at a clock edge, `dst_o`, `done_o` and `busy_o` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| hi_sel_i | input | 1 | 0 adds the low product half, 1 adds the high half |
| vlen_i | input | 2 | Vector-length code |
| mask_en_i | input | 1 | Enables per-lane masking |
| zero_mask_i | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| mask_i | input | 8 | Per-lane mask, bit n for lane n |
| src_a_i | input | 512 | First multiplicand vector |
| src_b_i | input | 512 | Second multiplicand vector |
| acc_i | input | 512 | Accumulator vector |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| dst_o | output | 512 | Result vector, held between completions |

## Verification
The assertions check on every cycle that the pipeline holds at most one operation in flight and that done lasts a single cycle. They also check that each lane's result register changes only at completion, and that at completion a merged lane returns exactly its staged accumulator while a cleared lane returns zero. The arithmetic itself can only be shown by the bench's scenarios, which compare each lane with a 128-bit reference product. These scenarios cover the choice of product half, operands with their upper bits set, accumulator wraparound, every mask pattern in both masking modes, the three vector lengths, and a start raised while busy.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

  localparam int unsigned PMAC_LANE_W = 64;
  localparam int unsigned PMAC_MUL_W  = 52;
  localparam int unsigned PMAC_LANES  = 8;

  typedef enum logic [1:0] {
    LM_SUM   = 2'd0,
    LM_KEEP  = 2'd1,
    LM_CLEAR = 2'd2
  } lane_mode_e;

  // number of active lanes for a vector-length code
  function automatic int unsigned vlen_lanes(input logic [1:0] code);
    case (code)
      2'b00:   return 2;
      2'b01:   return 4;
      default: return 8;
    endcase
  endfunction

  // lane write policy from activity and mask controls
  function automatic lane_mode_e pick_mode(input logic active, input logic mask_en,
                                           input logic mask_bit, input logic zero_mode);
    if (!active)                 return LM_CLEAR;
    if (!mask_en || mask_bit)    return LM_SUM;
    if (zero_mode)               return LM_CLEAR;
    return LM_KEEP;
  endfunction

endpackage

// File: rtl/pmac_ctrl.sv
module pmac_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic cap_o,
  output logic adv_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o
);

  logic stg1_q, stg2_q, done_q;

  assign busy_o = stg1_q | stg2_q;
  assign cap_o  = start_i & ~busy_o;
  assign adv_o  = stg1_q;
  assign fin_o  = stg2_q;
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      stg1_q <= cap_o;
      stg2_q <= stg1_q;
      done_q <= stg2_q;
    end
  end

  // one operation in flight at a time
  assert_one_inflight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stg1_q, stg2_q, done_q}));

  // done lasts a single cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // a start seen while busy must not start a fresh operation
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> !stg1_q);

endmodule

// File: rtl/pmac_lane.sv
module pmac_lane
  import pmac_pkg::*;
#(
  parameter int unsigned LANE_W = PMAC_LANE_W,
  parameter int unsigned MUL_W  = PMAC_MUL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              adv_i,
  input  logic              fin_i,
  input  logic              hi_i,
  input  lane_mode_e        mode_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic [LANE_W-1:0] acc_i,
  output logic [LANE_W-1:0] res_o
);

  localparam int unsigned PROD_W = 2 * MUL_W;

  function automatic logic [LANE_W-1:0] take_half(input logic [PROD_W-1:0] p,
                                                  input logic hi);
    logic [MUL_W-1:0] h;
    h = hi ? p[PROD_W-1:MUL_W] : p[MUL_W-1:0];
    return LANE_W'(h);
  endfunction

  logic [MUL_W-1:0]  a1_q, b1_q;
  logic [LANE_W-1:0] acc1_q, acc2_q, res_q;
  logic              hi1_q, hi2_q;
  lane_mode_e        mode1_q, mode2_q;
  logic [PROD_W-1:0] prod2_q;
  logic [PROD_W-1:0] prod_w;
  logic [LANE_W-1:0] sum_w;

  assign prod_w = PROD_W'(a1_q) * PROD_W'(b1_q);
  assign sum_w  = acc2_q + take_half(prod2_q, hi2_q);
  assign res_o  = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a1_q    <= '0;
      b1_q    <= '0;
      acc1_q  <= '0;
      hi1_q   <= 1'b0;
      mode1_q <= LM_CLEAR;
      prod2_q <= '0;
      acc2_q  <= '0;
      hi2_q   <= 1'b0;
      mode2_q <= LM_CLEAR;
      res_q   <= '0;
    end else begin
      if (cap_i) begin
        a1_q    <= a_i[MUL_W-1:0];
        b1_q    <= b_i[MUL_W-1:0];
        acc1_q  <= acc_i;
        hi1_q   <= hi_i;
        mode1_q <= mode_i;
      end
      if (adv_i) begin
        prod2_q <= prod_w;
        acc2_q  <= acc1_q;
        hi2_q   <= hi1_q;
        mode2_q <= mode1_q;
      end
      if (fin_i) begin
        case (mode2_q)
          LM_SUM:  res_q <= sum_w;
          LM_KEEP: res_q <= acc2_q;
          default: res_q <= '0;
        endcase
      end
    end
  end

  assert_merge_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && mode2_q == LM_KEEP) |=> res_o == $past(acc2_q));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && mode2_q == LM_CLEAR) |=> res_o == '0);

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> $stable(res_o));

endmodule

// File: rtl/pmac52_unit.sv
module pmac52_unit
  import pmac_pkg::*;
#(
  parameter int unsigned LANES  = PMAC_LANES,
  parameter int unsigned LANE_W = PMAC_LANE_W,
  parameter int unsigned MUL_W  = PMAC_MUL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    hi_sel_i,
  input  logic [1:0]              vlen_i,
  input  logic                    mask_en_i,
  input  logic                    zero_mask_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*LANE_W-1:0] src_a_i,
  input  logic [LANES*LANE_W-1:0] src_b_i,
  input  logic [LANES*LANE_W-1:0] acc_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [LANES*LANE_W-1:0] dst_o
);

  logic        cap_w, adv_w, fin_w;
  int unsigned live_w;

  assign live_w = (vlen_lanes(vlen_i) < LANES) ? vlen_lanes(vlen_i) : LANES;

  pmac_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cap_o   (cap_w),
    .adv_o   (adv_w),
    .fin_o   (fin_w),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    lane_mode_e mode_w;
    assign mode_w = pick_mode(n < live_w, mask_en_i, mask_i[n], zero_mask_i);

    pmac_lane #(.LANE_W(LANE_W), .MUL_W(MUL_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (cap_w),
      .adv_i  (adv_w),
      .fin_i  (fin_w),
      .hi_i   (hi_sel_i),
      .mode_i (mode_w),
      .a_i    (src_a_i[n*LANE_W +: LANE_W]),
      .b_i    (src_b_i[n*LANE_W +: LANE_W]),
      .acc_i  (acc_i[n*LANE_W +: LANE_W]),
      .res_o  (dst_o[n*LANE_W +: LANE_W])
    );
  end

  // done only ever follows the stage that feeds the result registers
  assert_done_after_fin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(fin_w));

endmodule

// File: tb/tb_pmac52_unit.sv
module tb_pmac52_unit;

  localparam int L = 8;
  localparam int W = 64;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i, hi_sel_i, mask_en_i, zero_mask_i;
  logic [1:0]     vlen_i;
  logic [L-1:0]   mask_i;
  logic [L*W-1:0] src_a_i, src_b_i, acc_i;
  logic           busy_o, done_o;
  logic [L*W-1:0] dst_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pmac52_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hi_sel_i(hi_sel_i),
    .vlen_i(vlen_i), .mask_en_i(mask_en_i), .zero_mask_i(zero_mask_i),
    .mask_i(mask_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .acc_i(acc_i),
    .busy_o(busy_o), .done_o(done_o), .dst_o(dst_o)
  );

  function automatic logic [63:0] ref_sum(input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] acc, input logic hi);
    logic [127:0] wide;
    logic [63:0]  part;
    wide = {76'd0, a[51:0]} * {76'd0, b[51:0]};
    if (hi) part = (wide >> 52) & 128'h000F_FFFF_FFFF_FFFF;
    else    part = wide[63:0] & 64'h000F_FFFF_FFFF_FFFF;
    return acc + part;
  endfunction

  function automatic logic [L*W-1:0] ref_vec(input logic [L*W-1:0] a, input logic [L*W-1:0] b,
      input logic [L*W-1:0] acc, input logic hi, input logic [1:0] vl,
      input logic men, input logic zm, input logic [L-1:0] m);
    logic [L*W-1:0] r;
    int live;
    live = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
    for (int n = 0; n < L; n++) begin
      if (n >= live)                r[n*W +: W] = '0;
      else if (men && !m[n])        r[n*W +: W] = zm ? 64'd0 : acc[n*W +: W];
      else                          r[n*W +: W] = ref_sum(a[n*W +: W], b[n*W +: W], acc[n*W +: W], hi);
    end
    return r;
  endfunction

  task automatic check1(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [L*W-1:0] exp);
    for (int n = 0; n < L; n++) begin
      checks++;
      if (dst_o[n*W +: W] !== exp[n*W +: W]) begin
        fails++;
        $display("FAIL %s lane %0d: got %h expected %h", req, n, dst_o[n*W +: W], exp[n*W +: W]);
      end
    end
  endtask

  function automatic logic [L*W-1:0] rnd_vec();
    logic [L*W-1:0] v;
    for (int k = 0; k < L*2; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // one full operation with latency checks (R10) and lane comparison
  task automatic run_op(input string req, input logic [L*W-1:0] a, input logic [L*W-1:0] b,
      input logic [L*W-1:0] acc, input logic hi, input logic [1:0] vl,
      input logic men, input logic zm, input logic [L-1:0] m);
    logic [L*W-1:0] exp;
    exp = ref_vec(a, b, acc, hi, vl, men, zm, m);
    @(negedge clk);
    src_a_i = a; src_b_i = b; acc_i = acc; hi_sel_i = hi; vlen_i = vl;
    mask_en_i = men; zero_mask_i = zm; mask_i = m; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    check1("R10 done low after 1", 64'(done_o), 64'd0);
    @(posedge clk); @(negedge clk);
    check1("R10 done low after 2", 64'(done_o), 64'd0);
    @(posedge clk); @(negedge clk);
    check1("R10 done high after 3", 64'(done_o), 64'd1);
    check_vec(req, exp);
    @(posedge clk); @(negedge clk);
    check1("R10 done single cycle", 64'(done_o), 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b1; hi_sel_i = 0; vlen_i = 2'b10; mask_en_i = 0;
    zero_mask_i = 0; mask_i = '1; src_a_i = '1; src_b_i = '1; acc_i = '1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check1("R12 done", 64'(done_o), 64'd0);
    check1("R12 busy", 64'(busy_o), 64'd0);
    check_vec("R12 dst", '0);
    start_i = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_low_half();
    for (int k = 0; k < 4; k++)
      run_op("R2 low half", rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, 2'b10, 1'b0, 1'b0, '0);
    run_op("R2 small values", {L{64'd7}}, {L{64'd9}}, {L{64'd100}}, 1'b0, 2'b10, 1'b0, 1'b0, '0);
  endtask

  task automatic t_high_half_ones();
    run_op("R1 R3 all ones high", '1, '1, '0, 1'b1, 2'b11, 1'b0, 1'b0, '0);
    run_op("R1 R2 all ones low", '1, '1, '0, 1'b0, 2'b11, 1'b0, 1'b0, '0);
    for (int k = 0; k < 4; k++)
      run_op("R3 high half", rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, 2'b10, 1'b0, 1'b0, '0);
    // upper operand bits toggled only: same result expected
    run_op("R1 upper bits ignored", {L{64'hFFF0_0000_0000_0003}}, {L{64'hABC0_0000_0000_0005}},
           {L{64'd1}}, 1'b0, 2'b10, 1'b0, 1'b0, '0);
  endtask

  task automatic t_wrap();
    run_op("R4 wrap low", '1, '1, '1, 1'b0, 2'b10, 1'b0, 1'b0, '0);
    run_op("R4 wrap high", '1, '1, {L{64'hFFFF_FFFF_FFFF_FF00}}, 1'b1, 2'b10, 1'b0, 1'b0, '0);
  endtask

  task automatic t_masks();
    logic [L*W-1:0] a, b, c;
    a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
    for (int m = 0; m < 256; m++) begin
      run_op("R5 R6 merge mask", a, b, c, m[0], 2'b10, 1'b1, 1'b0, m[7:0]);
      run_op("R5 R7 zero mask", a, b, c, m[1], 2'b10, 1'b1, 1'b1, m[7:0]);
    end
  endtask

  task automatic t_nomask();
    run_op("R8 mask ignored zero", rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, 2'b10, 1'b0, 1'b1, 8'h00);
    run_op("R8 mask ignored merge", rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, 2'b10, 1'b0, 1'b0, 8'h5A);
  endtask

  task automatic t_vlen();
    for (int v = 0; v < 4; v++) begin
      run_op("R9 vlen nomask", rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, v[1:0], 1'b0, 1'b0, '0);
      run_op("R9 vlen merge all set", rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, v[1:0], 1'b1, 1'b0, 8'hFF);
      run_op("R9 vlen merge partial", rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, v[1:0], 1'b1, 1'b0, 8'hA5);
    end
  endtask

  task automatic t_busy();
    logic [L*W-1:0] a, b, c, exp, held;
    a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
    exp = ref_vec(a, b, c, 1'b0, 2'b10, 1'b0, 1'b0, '0);
    @(negedge clk);
    src_a_i = a; src_b_i = b; acc_i = c; hi_sel_i = 0; vlen_i = 2'b10;
    mask_en_i = 0; zero_mask_i = 0; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    check1("R11 busy after start", 64'(busy_o), 64'd1);
    src_a_i = rnd_vec(); src_b_i = rnd_vec(); acc_i = rnd_vec(); hi_sel_i = 1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check1("R11 first op done", 64'(done_o), 64'd1);
    check_vec("R11 first op kept", exp);
    held = dst_o;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      check1("R11 no second done", 64'(done_o), 64'd0);
    end
    check_vec("R10 R11 result held", held);
  endtask

  initial begin
    t_reset();
    t_low_half();
    t_high_half_ones();
    t_wrap();
    t_masks();
    t_nomask();
    t_vlen();
    t_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule